// File: doc/BRIEF.md
# Dual-Page Two-Wire Memory Slave

This block is a two-wire serial slave that answers two device addresses. It oversamples the SCL and SDA lines on the system clock. Each address opens its own page of 256 byte-wide registers. The identification page (device 7'b1010000) can be read and written by the host. The diagnostics page (device 7'b1010001) can be read by the host. Host writes to it are acknowledged but thrown away. Only a local parallel port on the chip side can fill it, for example a power-monitor block posting new readings.

A single word pointer is shared by both pages. It is loaded by the word-address byte and advances by one after every data byte, in both directions. It wraps from 255 to 0. This supports several transfer types:
- byte and sequential writes;
- current-address reads, which continue from where the pointer stands;
- random reads, made of a word-address write followed by a repeated START and a read.

The pad side is a single active-high drive-enable. When it is 1, the pad pulls SDA low. When it is 0, SDA is released.

The control is one state machine with these states:
- ST_IDLE: waits for a START.
- ST_DEV: shifts in the device byte.
- ST_DEV_ACK: acknowledges a matching device byte.
- ST_WADDR: shifts in the word address.
- ST_WADDR_ACK: acknowledges the word address.
- ST_WDATA: shifts in a write data byte.
- ST_WDATA_ACK: acknowledges a write data byte.
- ST_RDATA: shifts out a read data byte.
- ST_RACK: samples the master's acknowledge bit.

The transitions are:
- A START enters ST_DEV from any state, and a STOP returns to ST_IDLE from any state.
- ST_DEV goes to ST_DEV_ACK on a match, or to ST_IDLE on a mismatch.
- ST_DEV_ACK goes to ST_WADDR for a write, or to ST_RDATA for a read.
- The write path runs ST_WADDR → ST_WADDR_ACK → ST_WDATA, then loops ST_WDATA ↔ ST_WDATA_ACK.
- The read path loops ST_RDATA ↔ ST_RACK while the master acknowledges. A master NACK sends ST_RACK to ST_IDLE.

Top module: `dual_page_i2c_slave`

## Requirements
- R1: After reset the SDA drive-enable is 0, every byte of both pages reads 0, and the word pointer is 0.
- R2: A device byte whose upper seven bits are 7'b1010000 (identification page) or 7'b1010001 (diagnostics page) is acknowledged by pulling SDA low during the ninth SCL pulse. The lowest bit of the device byte selects read (1) or write (0).
- R3: A device byte with any other upper seven bits gets no acknowledge, and the slave ignores the bus until the next START.
- R4: A write to the identification page (device byte, word address, data) acknowledges each byte and stores the data at the word address.
- R5: Each data byte advances the word pointer by one, and the pointer wraps from 255 to 0 within the selected page.
- R6: Host writes to the diagnostics page are acknowledged and advance the pointer, but they leave the page contents unchanged.
- R7: A clock cycle with loc_we high stores loc_wdata at loc_addr in the diagnostics page.
- R8: A repeated START after the word-address byte followed by a read returns data starting at that address. A read with no word address continues from the current pointer.
- R9: During a read, a master ACK makes the slave send the next byte. A master NACK ends the transfer, and SDA is released.
- R10: Read data is sent MSB first, with a 0 bit driven low. The drive-enable changes only while the filtered SCL is low.
- R11: A pulse on SCL or SDA lasting fewer than FILT_CYC system clocks after the synchronizer has no effect on the bus decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (as seen on the wire) |
| sda_drive_o | output | 1 | 1 = pull SDA low, 0 = release |
| loc_we | input | 1 | Local write strobe for the diagnostics page |
| loc_addr | input | AW | Local write address |
| loc_wdata | input | 8 | Local write data |

## Verification
The address decoder is swept over all 128 seven-bit device addresses. This shows that exactly the two page addresses are acknowledged and that a mismatched address also leaves the following byte unacknowledged. Sequential writes and reads are run across the 255-to-0 boundary with address-dependent data patterns. A wrong increment, a missing wrap, or swapped pages therefore all show up as data mismatches.

Several short sequences target specific paths:
- Host writes to the diagnostics page, then read-back, separate discard from acknowledge.
- Current-address reads directly after a random read check that the pointer is retained.
- A one-cycle SCL dropout inside a write byte checks the input filter.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } dps_state_t;

    localparam int unsigned PAGE_ID   = 0;
    localparam int unsigned PAGE_DIAG = 1;
    localparam int unsigned NUM_PAGES = 2;
    localparam int unsigned BYTE_W    = 8;

endpackage

// File: rtl/dps_line_filter.sv
module dps_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);

    localparam int CW = $clog2(FILT_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   lvl_q;
    logic                   rise_q;
    logic                   fall_q;
    logic                   smp;
    logic                   settle;

    assign smp    = sync_q[SYNC_STAGES-1];
    assign settle = (smp != lvl_q) && (cnt_q == CW'(FILT_CYC - 1));

    // Synchronizer chain, idles high like a pulled-up line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
        end
    end

    // A new level is accepted only after FILT_CYC equal samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lvl_q  <= 1'b1;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= settle & smp;
            fall_q <= settle & ~smp;
            if (smp == lvl_q) begin
                cnt_q <= '0;
            end else if (settle) begin
                lvl_q <= smp;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign lvl_o  = lvl_q;
    assign rise_o = rise_q;
    assign fall_o = fall_q;

    AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(smp))) else $error("filter level jumped"); // R11

endmodule

// File: rtl/dps_page_mem.sv
module dps_page_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/dual_page_i2c_slave.sv
module dual_page_i2c_slave
    import dps_pkg::*;
#(
    parameter logic [6:0] ID_DEV      = 7'b1010000,
    parameter logic [6:0] DIAG_DEV    = 7'b1010001,
    parameter int         AW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_CYC    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_drive_o,
    input  logic                loc_we,
    input  logic [AW-1:0]       loc_addr,
    input  logic [BYTE_W-1:0]   loc_wdata
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    // Conditioned bus lines
    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_det, stop_det;

    dps_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(scl_i),
        .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    dps_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(sda_i),
        .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    assign start_det = sda_fall & scl_lvl;
    assign stop_det  = sda_rise & scl_lvl;

    // Registered control state
    dps_state_t         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [BYTE_W-1:0]  shreg_q, shreg_d;
    logic [BYTE_W-1:0]  tx_q, tx_d;
    logic [AW-1:0]      ptr_q, ptr_d;
    logic               sel_q, sel_d;      // 0 = identification, 1 = diagnostics
    logic               rw_q, rw_d;
    logic               ackin_q, ackin_d;
    logic               drive_q, drive_d;
    logic               host_wr;

    // Page storage
    logic [BYTE_W-1:0]  page_rdata [NUM_PAGES];
    logic [BYTE_W-1:0]  rd_byte;

    assign rd_byte = page_rdata[sel_q];

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
        if (g == PAGE_ID) begin : g_host_page
            dps_page_mem #(.AW(AW), .DW(BYTE_W)) u_mem (
                .clk(clk), .rst_n(rst_n),
                .we_i(host_wr & ~sel_q), .waddr_i(ptr_q), .wdata_i(shreg_q),
                .raddr_i(ptr_q), .rdata_o(page_rdata[g])
            );
        end else begin : g_local_page
            dps_page_mem #(.AW(AW), .DW(BYTE_W)) u_mem (
                .clk(clk), .rst_n(rst_n),
                .we_i(loc_we), .waddr_i(loc_addr), .wdata_i(loc_wdata),
                .raddr_i(ptr_q), .rdata_o(page_rdata[g])
            );
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            sel_q   <= 1'b0;
            rw_q    <= 1'b0;
            ackin_q <= 1'b0;
            drive_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            shreg_q <= shreg_d;
            tx_q    <= tx_d;
            ptr_q   <= ptr_d;
            sel_q   <= sel_d;
            rw_q    <= rw_d;
            ackin_q <= ackin_d;
            drive_q <= drive_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        shreg_d = shreg_q;
        tx_d    = tx_q;
        ptr_d   = ptr_q;
        sel_d   = sel_q;
        rw_d    = rw_q;
        ackin_d = ackin_q;
        drive_d = drive_q;
        host_wr = 1'b0;

        if (stop_det) begin
            state_d = ST_IDLE;
            drive_d = 1'b0;
        end else if (start_det) begin
            state_d = ST_DEV;
            cnt_d   = '0;
            drive_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_DEV: begin
                    if (scl_rise) begin
                        shreg_d = {shreg_q[BYTE_W-2:0], sda_lvl};
                        cnt_d   = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
                        if (shreg_q[7:1] == ID_DEV || shreg_q[7:1] == DIAG_DEV) begin
                            sel_d   = (shreg_q[7:1] == DIAG_DEV);
                            rw_d    = shreg_q[0];
                            drive_d = 1'b1;
                            state_d = ST_DEV_ACK;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        cnt_d = '0;
                        if (rw_q) begin
                            tx_d    = rd_byte;
                            drive_d = ~rd_byte[BYTE_W-1];
                            state_d = ST_RDATA;
                        end else begin
                            drive_d = 1'b0;
                            state_d = ST_WADDR;
                        end
                    end
                end
                ST_WADDR: begin
                    if (scl_rise) begin
                        shreg_d = {shreg_q[BYTE_W-2:0], sda_lvl};
                        cnt_d   = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
                        ptr_d   = shreg_q[AW-1:0];
                        drive_d = 1'b1;
                        state_d = ST_WADDR_ACK;
                    end
                end
                ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        drive_d = 1'b0;
                        cnt_d   = '0;
                        state_d = ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        shreg_d = {shreg_q[BYTE_W-2:0], sda_lvl};
                        cnt_d   = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
                        host_wr = 1'b1;
                        ptr_d   = ptr_q + 1'b1;
                        drive_d = 1'b1;
                        state_d = ST_WDATA_ACK;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        cnt_d = cnt_q + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt_q == CNT_W'(BYTE_W)) begin
                            drive_d = 1'b0;
                            ptr_d   = ptr_q + 1'b1;
                            state_d = ST_RACK;
                        end else if (cnt_q != '0) begin
                            tx_d    = tx_q << 1;
                            drive_d = ~tx_q[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        ackin_d = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (ackin_q) begin
                            cnt_d   = '0;
                            tx_d    = rd_byte;
                            drive_d = ~rd_byte[BYTE_W-1];
                            state_d = ST_RDATA;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign sda_drive_o = drive_q;

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_q != $past(drive_q)) |-> !scl_lvl) else $error("drive moved with SCL high"); // R10

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !drive_q) else $error("idle but driving"); // R3

    AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV_ACK && $past(state_q) == ST_DEV) |-> drive_q) else $error("match not acked"); // R2

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDATA_ACK && $past(state_q) == ST_WDATA) |-> (ptr_q == $past(ptr_q) + 1'b1)) else $error("pointer step"); // R5

    AST_NACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RACK && state_q == ST_RDATA) |-> $past(ackin_q)) else $error("read went on after nack"); // R9

endmodule

// File: tb/tb_dual_page_i2c_slave.sv
module tb_dual_page_i2c_slave;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       loc_we = 1'b0;
    logic [7:0] loc_addr = '0;
    logic [7:0] loc_wdata = '0;
    logic       sda_drive_o;
    logic       sda_line;

    int checks = 0;
    int fails  = 0;
    logic [7:0] got [32];

    always #5 clk = ~clk;

    assign sda_line = m_sda & ~sda_drive_o;

    dual_page_i2c_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_drive_o(sda_drive_o), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata)
    );

    function automatic logic [7:0] id_pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] diag_pat(input int a);
        return 8'(((a ^ 8'h5A) + (a >> 3)) & 255);
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(); m_scl = 1'b1;
            if (glitch) begin
                repeat (Q / 2) @(negedge clk);
                m_scl = 1'b0; @(negedge clk); m_scl = 1'b1;
                repeat (Q / 2 - 1) @(negedge clk);
            end else begin
                wq();
            end
            m_scl = 1'b0; wq();
        end
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
        ack = (sda_line == 1'b0);
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wq(); m_scl = 1'b1; wq(); b[i] = sda_line; m_scl = 1'b0;
        end
        m_sda = give_ack ? 1'b0 : 1'b1; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    // Random read of n bytes from dev at addr into got[]
    task automatic rand_read(input logic [6:0] dev, input logic [7:0] addr, input int n);
        bit a;
        bus_start();
        send_byte({dev, 1'b0}, 1'b0, a);
        send_byte(addr, 1'b0, a);
        bus_start();
        send_byte({dev, 1'b1}, 1'b0, a);
        chk(a, "R8 read device ack", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, got[i]);
        end
        chk(sda_drive_o == 1'b0, "R9 release after nack", sda_drive_o, 0);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        bit a;
        logic [7:0] b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: released and zero contents at pointer 0
        chk(sda_drive_o == 1'b0, "R1 drive after reset", sda_drive_o, 0);
        bus_start();
        send_byte(8'hA1, 1'b0, a);
        recv_byte(1'b0, b);
        chk(b == 8'h00, "R1 id page byte 0 after reset", b, 0);
        bus_stop();

        // R7: fill diagnostics page through the local port
        for (int i = 0; i < 256; i++) begin
            loc_we = 1'b1; loc_addr = 8'(i); loc_wdata = diag_pat(i);
            @(negedge clk);
        end
        loc_we = 1'b0;

        // R2 / R3: sweep every seven-bit device address
        for (int d = 0; d < 128; d++) begin
            bit hit;
            hit = (d == 'h50) || (d == 'h51);
            bus_start();
            send_byte({7'(d), 1'b0}, 1'b0, a);
            if (hit) chk(a == 1'b1, "R2 page address acked", a, 1);
            else begin
                chk(a == 1'b0, "R3 foreign address not acked", a, 0);
                send_byte(8'h00, 1'b0, a);
                chk(a == 1'b0, "R3 byte after foreign address ignored", a, 0);
            end
            bus_stop();
        end

        // R4 / R5: sequential write across the wrap
        bus_start();
        send_byte(8'hA0, 1'b0, a);  chk(a, "R4 device ack", a, 1);
        send_byte(8'd250, 1'b0, a); chk(a, "R4 word address ack", a, 1);
        for (int i = 0; i < 14; i++) begin
            send_byte(id_pat((250 + i) & 255), 1'b0, a);
            chk(a, "R4 data ack", a, 1);
        end
        bus_stop();

        // R8 / R5 / R10: random sequential read across the wrap
        rand_read(7'h50, 8'd250, 12);
        for (int i = 0; i < 12; i++) begin
            chk(got[i] == id_pat((250 + i) & 255), "R5 R10 wrapped read data", got[i], id_pat((250 + i) & 255));
        end

        // R8: current-address reads continue at pointer 6, then 7
        for (int k = 6; k < 8; k++) begin
            bus_start();
            send_byte(8'hA1, 1'b0, a);
            recv_byte(1'b0, b);
            chk(b == id_pat(k), "R8 current address read", b, id_pat(k));
            bus_stop();
        end

        // R11: SCL dropout of one cycle inside every bit of a data byte
        bus_start();
        send_byte(8'hA0, 1'b0, a);
        send_byte(8'd100, 1'b0, a);
        send_byte(8'h96, 1'b1, a);
        chk(a, "R11 glitched byte acked", a, 1);
        bus_stop();
        rand_read(7'h50, 8'd100, 1);
        chk(got[0] == 8'h96, "R11 glitched byte stored", got[0], 8'h96);

        // R6: host write to diagnostics page is acked and dropped
        bus_start();
        send_byte(8'hA2, 1'b0, a);  chk(a, "R6 diag device ack", a, 1);
        send_byte(8'd3, 1'b0, a);   chk(a, "R6 diag word ack", a, 1);
        send_byte(8'hC3, 1'b0, a);  chk(a, "R6 diag data ack", a, 1);
        bus_stop();
        rand_read(7'h51, 8'd3, 1);
        chk(got[0] == diag_pat(3), "R6 diag byte unchanged", got[0], diag_pat(3));

        // R7 / R9: long diagnostics read across the wrap
        rand_read(7'h51, 8'd240, 32);
        for (int i = 0; i < 32; i++) begin
            chk(got[i] == diag_pat((240 + i) & 255), "R7 R9 diag sequential read", got[i], diag_pat((240 + i) & 255));
        end

        // R7: single local overwrite
        @(negedge clk);
        loc_we = 1'b1; loc_addr = 8'd17; loc_wdata = 8'h3C;
        @(negedge clk);
        loc_we = 1'b0;
        rand_read(7'h51, 8'd17, 2);
        chk(got[0] == 8'h3C, "R7 local overwrite", got[0], 8'h3C);
        chk(got[1] == diag_pat(18), "R7 neighbour untouched", got[1], diag_pat(18));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule